// File: doc/BRIEF.md
# Recovered-Clock Frequency Lock Detector

This block decides whether a clock-recovery loop should follow incoming data or fall back to a local reference clock. It does this by measuring the recovered clock against that reference. A timer in the reference domain marks out back-to-back windows of `WIN_LEN` reference cycles. A counter in the recovered-clock domain runs freely. At each window boundary the reference side raises a toggle request. The recovered side answers by freezing a snapshot of its counter and toggling an acknowledge. Once the acknowledge has been synchronised, the reference side subtracts the previous snapshot from the new one. The result is the number of recovered cycles per window. The block compares this number with `WIN_LEN*RATIO` and accepts it when the absolute deviation is no larger than the programmable tolerance `cfg_tol`.

A three-state controller acts on these window verdicts and on the signal-detect input. In the reference state the loop is told to track the reference. After `HOLD_WIN` windows with signal present, the controller releases the loop for a trial. The trial lasts at most `cfg_try` windows. The first passing window during the trial declares lock. If every window in the trial fails, the controller returns to the reference. Once locked, a single failing window sends the loop back to the reference. Losing signal detect does the same at once.

Top module: `fld_top`

## Requirements
- R1: While `rst` is high, and afterwards until a window verdict changes the state, `lock_det` is 0 and `ref_sel` is 1 (reference state).
- R2: Each window verdict counts the recovered-clock cycles between two consecutive snapshots taken one window of `WIN_LEN` reference cycles apart, and passes when |count - `WIN_LEN*RATIO`| <= `cfg_tol`. A new window request is never issued while the previous one is still unacknowledged. A window in which the recovered rate changes part-way fails.
- R3: In the lock state (`lock_det`=1, `ref_sel`=0), one failing verdict moves the block straight to the reference state (`lock_det`=0, `ref_sel`=1).
- R4: In the reference state with `sig_det` high, the `HOLD_WIN`-th verdict moves the block to the trial state (`lock_det`=0, `ref_sel`=0). The pass or fail value of these verdicts is not used. Leaving the reference state always leads to the trial state and never directly to lock.
- R5: In the trial state, a passing verdict moves the block to the lock state. Lock is entered only from the trial state.
- R6: In the trial state, failing verdicts are counted. On the `cfg_try`-th consecutive failure the block returns to the reference state. A `cfg_try` of 0 acts as 1.
- R7: When `sig_det` is low at a reference-clock edge, the next state is the reference state, whatever the current state. The hold count restarts from zero, and verdicts arriving meanwhile are ignored.
- R8: The first verdict after reset has no earlier snapshot to subtract from, so it is discarded and does not count towards the hold count.
- R9: `cfg_tol` is sampled when a verdict is formed. Widening it makes a steady rate offset pass.
- R10: `lock_det` and `ref_sel` are never both high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| ref_clk | input | 1 | Local reference clock; the controller runs on it |
| rst | input | 1 | Synchronous active-high reset in the reference domain; re-synchronised into the recovered domain |
| rec_clk | input | 1 | Recovered clock being measured |
| sig_det | input | 1 | Signal present, synchronous to `ref_clk`; low forces the reference state |
| cfg_tol | input | TOL_W | Allowed deviation in recovered cycles per window |
| cfg_try | input | TRY_W | Maximum number of windows in one trial |
| lock_det | output | 1 | High in the lock state |
| ref_sel | output | 1 | High when the loop must track the reference clock |

## Verification
The recovered clock is driven at the nominal 2:1 ratio and at a steady 1.5:1 offset. It is switched between the two just after window boundaries. This separates steady passing windows, steady failing windows and the mixed windows that straddle a rate change. The offset is tried with both a narrow and a wide tolerance, which shows that the tolerance is applied when the verdict is formed rather than being fixed. Signal detect is dropped while the block is locked and then restored. This shows that the override acts on the next edge and that the hold count restarts. The first window after reset is watched to confirm it does not count towards the hold.

// File: rtl/fld_pkg.sv
package fld_pkg;

    typedef enum logic [1:0] {
        ST_REF  = 2'd0,
        ST_TRY  = 2'd1,
        ST_LOCK = 2'd2
    } lk_state_e;

    typedef struct packed {
        logic valid;
        logic pass;
    } win_res_t;

    // absolute deviation of a measured count from the nominal count
    function automatic logic [31:0] abs_dev(input logic [31:0] cnt, input logic [31:0] nom);
        return (cnt >= nom) ? (cnt - nom) : (nom - cnt);
    endfunction

endpackage

// File: rtl/fld_sync.sv
module fld_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] chain;

    always_ff @(posedge clk) begin
        if (rst) chain <= '0;
        else     chain <= {chain[STAGES-2:0], d};
    end

    assign q = chain[STAGES-1];
endmodule

// File: rtl/fld_ref_timer.sv
module fld_ref_timer #(
    parameter int WIN_LEN = 64
) (
    input  logic clk,
    input  logic rst,
    output logic req_tgl
);
    localparam int WC_W = (WIN_LEN > 2) ? $clog2(WIN_LEN) : 1;
    localparam logic [WC_W-1:0] LAST = WC_W'(WIN_LEN - 1);

    logic [WC_W-1:0] wcnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            wcnt    <= '0;
            req_tgl <= 1'b0;
        end else if (wcnt == LAST) begin
            wcnt    <= '0;
            req_tgl <= ~req_tgl;
        end else begin
            wcnt    <= wcnt + 1'b1;
        end
    end
endmodule

// File: rtl/fld_rec_counter.sv
module fld_rec_counter #(
    parameter int CNT_W  = 10,
    parameter int STAGES = 2
) (
    input  logic             rec_clk,
    input  logic             rst,
    input  logic             req_tgl,
    output logic [CNT_W-1:0] snap,
    output logic             ack_tgl
);
    logic rec_rst;
    logic req_s;
    logic [CNT_W-1:0] run_cnt;

    // reset brought into the recovered domain
    fld_sync #(.STAGES(STAGES)) u_rst_sync (
        .clk(rec_clk), .rst(1'b0), .d(rst), .q(rec_rst)
    );

    fld_sync #(.STAGES(STAGES)) u_req_sync (
        .clk(rec_clk), .rst(rec_rst), .d(req_tgl), .q(req_s)
    );

    always_ff @(posedge rec_clk) begin
        if (rec_rst) begin
            run_cnt <= '0;
            snap    <= '0;
            ack_tgl <= 1'b0;
        end else begin
            run_cnt <= run_cnt + 1'b1;
            if (req_s != ack_tgl) begin
                snap    <= run_cnt;
                ack_tgl <= req_s;
            end
        end
    end
endmodule

// File: rtl/fld_meas.sv
module fld_meas
    import fld_pkg::*;
#(
    parameter int CNT_W   = 10,
    parameter int NOM_CNT = 128,
    parameter int TOL_W   = 8,
    parameter int STAGES  = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             ack_tgl,
    input  logic [CNT_W-1:0] snap,
    input  logic [TOL_W-1:0] cfg_tol,
    output logic             ack_sync,
    output win_res_t         res
);
    logic             ack_seen;
    logic             primed;
    logic [CNT_W-1:0] prev_snap;
    logic [CNT_W-1:0] span;
    logic             in_tol;

    fld_sync #(.STAGES(STAGES)) u_ack_sync (
        .clk(clk), .rst(rst), .d(ack_tgl), .q(ack_sync)
    );

    assign span   = snap - prev_snap;
    assign in_tol = abs_dev(32'(span), 32'(NOM_CNT)) <= 32'(cfg_tol);

    always_ff @(posedge clk) begin
        if (rst) begin
            ack_seen  <= 1'b0;
            primed    <= 1'b0;
            prev_snap <= '0;
            res       <= '0;
        end else if (ack_sync != ack_seen) begin
            ack_seen  <= ack_sync;
            prev_snap <= snap;
            primed    <= 1'b1;
            res.valid <= primed;
            res.pass  <= in_tol;
        end else begin
            res.valid <= 1'b0;
        end
    end
endmodule

// File: rtl/fld_ctrl.sv
module fld_ctrl
    import fld_pkg::*;
#(
    parameter int HOLD_WIN = 2,
    parameter int TRY_W    = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             sig_det,
    input  win_res_t         res,
    input  logic [TRY_W-1:0] cfg_try,
    output logic             lock_det,
    output logic             ref_sel
);
    localparam int HC_W = $clog2(HOLD_WIN + 1);
    localparam logic [HC_W-1:0] HOLD_LAST = HC_W'(HOLD_WIN - 1);

    lk_state_e        state;
    logic [HC_W-1:0]  hold_cnt;
    logic [TRY_W-1:0] try_cnt;
    logic             try_last;

    assign try_last = ({1'b0, try_cnt} + 1'b1) >= {1'b0, cfg_try};

    always_ff @(posedge clk) begin
        if (rst) begin
            state    <= ST_REF;
            hold_cnt <= '0;
            try_cnt  <= '0;
        end else if (!sig_det) begin
            state    <= ST_REF;
            hold_cnt <= '0;
        end else if (res.valid) begin
            unique case (state)
                ST_REF: begin
                    if (hold_cnt == HOLD_LAST) begin
                        state    <= ST_TRY;
                        hold_cnt <= '0;
                        try_cnt  <= '0;
                    end else begin
                        hold_cnt <= hold_cnt + 1'b1;
                    end
                end
                ST_TRY: begin
                    if (res.pass) begin
                        state <= ST_LOCK;
                    end else if (try_last) begin
                        state    <= ST_REF;
                        hold_cnt <= '0;
                    end else begin
                        try_cnt <= try_cnt + 1'b1;
                    end
                end
                ST_LOCK: begin
                    if (!res.pass) begin
                        state    <= ST_REF;
                        hold_cnt <= '0;
                    end
                end
                default: state <= ST_REF;
            endcase
        end
    end

    assign lock_det = (state == ST_LOCK);
    assign ref_sel  = (state == ST_REF);
endmodule

// File: rtl/fld_top.sv
module fld_top
    import fld_pkg::*;
#(
    parameter int WIN_LEN  = 64,
    parameter int RATIO    = 2,
    parameter int HOLD_WIN = 2,
    parameter int TOL_W    = 8,
    parameter int TRY_W    = 4,
    parameter int STAGES   = 2
) (
    input  logic             ref_clk,
    input  logic             rst,
    input  logic             rec_clk,
    input  logic             sig_det,
    input  logic [TOL_W-1:0] cfg_tol,
    input  logic [TRY_W-1:0] cfg_try,
    output logic             lock_det,
    output logic             ref_sel
);
    localparam int NOM_CNT = WIN_LEN * RATIO;
    localparam int CNT_W   = $clog2(NOM_CNT * 4);

    logic             req_tgl;
    logic             ack_tgl;
    logic             ack_sync;
    logic [CNT_W-1:0] snap;
    win_res_t         res;

    fld_ref_timer #(.WIN_LEN(WIN_LEN)) u_timer (
        .clk(ref_clk), .rst(rst), .req_tgl(req_tgl)
    );

    fld_rec_counter #(.CNT_W(CNT_W), .STAGES(STAGES)) u_reccnt (
        .rec_clk(rec_clk), .rst(rst), .req_tgl(req_tgl),
        .snap(snap), .ack_tgl(ack_tgl)
    );

    fld_meas #(.CNT_W(CNT_W), .NOM_CNT(NOM_CNT), .TOL_W(TOL_W), .STAGES(STAGES)) u_meas (
        .clk(ref_clk), .rst(rst), .ack_tgl(ack_tgl), .snap(snap),
        .cfg_tol(cfg_tol), .ack_sync(ack_sync), .res(res)
    );

    fld_ctrl #(.HOLD_WIN(HOLD_WIN), .TRY_W(TRY_W)) u_ctrl (
        .clk(ref_clk), .rst(rst), .sig_det(sig_det), .res(res),
        .cfg_try(cfg_try), .lock_det(lock_det), .ref_sel(ref_sel)
    );
endmodule

// File: rtl/fld_chk.sv
module fld_chk (
    input logic ref_clk,
    input logic rst,
    input logic sig_det,
    input logic lock_det,
    input logic ref_sel,
    input logic req_tgl,
    input logic ack_sync
);
    // R1: reset leaves the reference state selected
    p_rst_state_r1: assert property (@(posedge ref_clk)
        rst |=> (ref_sel && !lock_det));

    // R2: a new window request only once the previous one came back
    p_hs_done_r2: assert property (@(posedge ref_clk) disable iff (rst)
        (req_tgl != $past(req_tgl)) |-> (ack_sync == $past(req_tgl)));

    // R3: losing lock goes straight to the reference
    p_unlock_ref_r3: assert property (@(posedge ref_clk) disable iff (rst)
        $fell(lock_det) |-> ref_sel);

    // R4: leaving the reference always enters the trial first
    p_ref_to_try_r4: assert property (@(posedge ref_clk) disable iff (rst)
        $fell(ref_sel) |-> !lock_det);

    // R5: lock is entered only from the trial state
    p_lock_from_try_r5: assert property (@(posedge ref_clk) disable iff (rst)
        $rose(lock_det) |-> !$past(ref_sel));

    // R7: signal loss forces the reference on the next edge
    p_sd_override_r7: assert property (@(posedge ref_clk) disable iff (rst)
        !sig_det |=> (ref_sel && !lock_det));
endmodule

bind fld_top fld_chk u_chk (
    .ref_clk (ref_clk),
    .rst     (rst),
    .sig_det (sig_det),
    .lock_det(lock_det),
    .ref_sel (ref_sel),
    .req_tgl (req_tgl),
    .ack_sync(ack_sync)
);

// File: tb/fld_top_tb.sv
`timescale 1ps/1ps
module fld_top_tb;
    localparam int WIN  = 64;
    localparam int NWIN = 22;
    localparam int GRACE = 14;

    logic       ref_clk = 1'b0;
    logic       rec_clk = 1'b0;
    logic       rst = 1'b1;
    logic       sig_det = 1'b1;
    logic [7:0] cfg_tol = 8'd4;
    logic [3:0] cfg_try = 4'd2;
    logic       lock_det;
    logic       ref_sel;

    int rec_half = 1250;
    int cyc = 0;
    int checks = 0;
    int fails = 0;
    bit run = 1'b0;
    bit done = 1'b0;

    // behavioural model state: 0 reference, 1 trial, 2 lock
    int m_st = 0, m_hold = 0, m_try = 0;
    logic e_lock = 1'b0, e_sel = 1'b1, o_lock = 1'b0, o_sel = 1'b1;
    int chg_cyc = -100;

    bit         good_a [NWIN];
    int         tol_a  [NWIN];
    bit         sd_a   [NWIN];
    logic [1:0] exp_a  [NWIN];   // {lock_det, ref_sel}
    string      tag_a  [NWIN];

    fld_top u_dut (
        .ref_clk(ref_clk), .rst(rst), .rec_clk(rec_clk), .sig_det(sig_det),
        .cfg_tol(cfg_tol), .cfg_try(cfg_try), .lock_det(lock_det), .ref_sel(ref_sel)
    );

    always #2500 ref_clk = ~ref_clk;
    always begin #(rec_half) rec_clk = ~rec_clk; end

    always @(posedge ref_clk) begin
        if (rst) cyc <= 0;
        else     cyc <= cyc + 1;
    end

    task automatic check(input string tag, input logic [1:0] got, input logic [1:0] exp);
        checks++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s got lock/sel=%b expected=%b at cycle %0d", tag, got, exp, cyc);
        end
    endtask

    task automatic model_go(input int st);
        logic nl, ns;
        m_st = st;
        nl = (st == 2);
        ns = (st == 0);
        if (nl != e_lock || ns != e_sel) begin
            o_lock = e_lock; o_sel = e_sel;
            e_lock = nl; e_sel = ns;
            chg_cyc = cyc;
        end
    endtask

    task automatic model_result(input bit pass);
        case (m_st)
            0: if (m_hold == 1) begin m_hold = 0; m_try = 0; model_go(1); end
               else m_hold++;
            1: if (pass) model_go(2);
               else if (m_try + 1 >= int'(cfg_try)) begin m_hold = 0; model_go(0); end
               else m_try++;
            default: if (!pass) begin m_hold = 0; model_go(0); end
        endcase
    endtask

    task automatic wait_cyc(input int t);
        while (cyc < t) begin @(posedge ref_clk); #1; end
    endtask

    task automatic set_win(input int j, input bit g, input int t, input bit s,
                           input logic [1:0] e, input string tg);
        good_a[j] = g; tol_a[j] = t; sd_a[j] = s; exp_a[j] = e; tag_a[j] = tg;
    endtask

    // every-cycle comparison against the model (R10 invariant included)
    always @(negedge ref_clk) begin
        if (run && !done) begin
            check("R10", {lock_det & ref_sel, 1'b0}, 2'b00);
            if (!((lock_det === e_lock && ref_sel === e_sel) ||
                  ((cyc - chg_cyc) < GRACE && lock_det === o_lock && ref_sel === o_sel)))
                check("R2 model", {lock_det, ref_sel}, {e_lock, e_sel});
            else
                checks++;
        end
    end

    initial begin
        #500_000_000;
        if (!done) begin
            done = 1'b1;
            fails++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        // REF=01, TRY=00, LOCK=10
        set_win(0,  1, 4,  1, 2'b01, "R1");
        set_win(1,  1, 4,  1, 2'b01, "R8");
        set_win(2,  1, 4,  1, 2'b00, "R4");
        set_win(3,  1, 4,  1, 2'b10, "R5");
        set_win(4,  1, 4,  1, 2'b10, "R2");
        set_win(5,  0, 4,  1, 2'b01, "R3");
        set_win(6,  0, 4,  1, 2'b01, "R4");
        set_win(7,  0, 4,  1, 2'b00, "R4");
        set_win(8,  0, 4,  1, 2'b00, "R6");
        set_win(9,  0, 4,  1, 2'b01, "R6");
        set_win(10, 0, 40, 1, 2'b01, "R4");
        set_win(11, 0, 40, 1, 2'b00, "R4");
        set_win(12, 0, 40, 1, 2'b10, "R9");
        set_win(13, 0, 4,  1, 2'b01, "R3");
        set_win(14, 1, 4,  1, 2'b01, "R2");
        set_win(15, 1, 4,  1, 2'b00, "R4");
        set_win(16, 1, 4,  1, 2'b10, "R5");
        set_win(17, 1, 4,  0, 2'b01, "R7");
        set_win(18, 1, 4,  1, 2'b01, "R7");
        set_win(19, 1, 4,  1, 2'b00, "R4");
        set_win(20, 1, 4,  1, 2'b10, "R5");
        set_win(21, 1, 4,  1, 2'b10, "R2");

        repeat (20) @(posedge ref_clk);
        @(negedge ref_clk);
        check("R1", {lock_det, ref_sel}, 2'b01);
        @(posedge ref_clk); #1;
        rst = 1'b0;
        run = 1'b1;

        for (int j = 1; j < NWIN; j++) begin
            wait_cyc(j * WIN + 20);
            sig_det  = sd_a[j];
            cfg_tol  = 8'(tol_a[j]);
            rec_half = good_a[j] ? 1250 : 1667;
            if (!sd_a[j]) begin
                m_hold = 0;
                model_go(0);
                @(negedge ref_clk);
                @(negedge ref_clk);
                check("R7", {lock_det, ref_sel}, 2'b01);
            end
            wait_cyc((j + 1) * WIN);
            if (sd_a[j])
                model_result((good_a[j] && good_a[j-1]) ||
                             (!good_a[j] && !good_a[j-1] && tol_a[j] >= 36));
            wait_cyc((j + 1) * WIN + 16);
            @(negedge ref_clk);
            check(tag_a[j], {lock_det, ref_sel}, exp_a[j]);
        end

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule